// File: doc/BRIEF.md
# Segmented Binary-to-Gray Address Converter

This block turns a binary address of `ADDR_W` bits into a Gray-coded address. A split point `SPLIT` (written k below) divides the word into two fields. The upper field covers bits `[ADDR_W-1:SPLIT]` and the lower field covers bits `[SPLIT-1:0]`. Each field is Gray-encoded by itself. The lower field therefore still selects a byte inside one machine word, while the upper field steps through words in Gray order with a stride of 2^k. Word sizes of 8, 16, 32 and 64 bits map to k = 0, 1, 2 and 3. When k = 0 the block is the plain full-width converter.

Every output bit is one XOR of two input bits, or a direct copy of one input bit. No XOR feeds another XOR, so the logic depth is the same for every width. There are n-1 XORs when k = 0 and n-2 when k > 0. The `REG_OUT` parameter selects between a registered output and a purely combinational one. In registered mode the output register loads only when the input strobe is high, and a valid flag follows the strobe by one clock. The build stops if k lies outside 0 to `ADDR_W-2`.

Top module: `gray_seg_conv`

## Requirements
- R1: The output MSB equals the input MSB: outGray[n-1] = inAddr[n-1].
- R2: For every bit j with k <= j < n-1, outGray[j] = inAddr[j+1] XOR inAddr[j].
- R3: When k > 0, the top bit of the lower field is copied: outGray[k-1] = inAddr[k-1].
- R4: When k > 1, for every bit j < k-1, outGray[j] = inAddr[j+1] XOR inAddr[j], using only lower-field bits.
- R5: With k = 0, outGray equals inAddr XOR (inAddr >> 1) over the whole word.
- R6: With REG_OUT = 1, outValid is high in exactly those cycles that follow a cycle with inValid high, and outGray then carries the conversion of the address presented with that strobe.
- R7: With REG_OUT = 1, a cycle with inValid low leaves outGray unchanged in the following cycle.
- R8: Active-low asynchronous reset rstN drives outGray to all zeros and outValid to 0.
- R9: With REG_OUT = 0, outGray is the conversion of the current inAddr in the same cycle, and outValid equals inValid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Strobe that marks inAddr as valid |
| inAddr | input | ADDR_W | Binary address |
| outValid | output | 1 | Marks outGray as valid |
| outGray | output | ADDR_W | Segmented Gray address |

## Verification
In registered mode, two things can happen in the same cycle. The output register can present one result while it captures the next strobe, and the valid flag can fall in the cycle that the held value must stay frozen. The bench drives long bursts of strobes on consecutive cycles, interleaved with idle gaps. A scoreboard queue pairs each raised outValid with the oldest pending expectation, and it checks each field separately. In cycles without valid, the monitor checks that the last result is held unchanged. A second instance with k = 0 and no register is checked in the same cycle as its input.

// File: rtl/gray_seg_pkg.sv
package gray_seg_pkg;
  typedef struct packed {
    logic load;   // capture a fresh conversion into the output register
  } segCtrl_t;
endpackage

// File: rtl/gray_seg_dp.sv
module gray_seg_dp
  import gray_seg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SPLIT   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] inAddr,
  input  segCtrl_t          ctrl,
  output logic [ADDR_W-1:0] grayOut
);
  localparam int TOP_BIT   = ADDR_W - 1;
  localparam int LOW_TOP   = SPLIT - 1;   // -1 when there is no lower field

  logic [ADDR_W-1:0] grayComb;

  // One flat layer: each bit is a copy or a single XOR of two inputs.
  for (genvar j = 0; j < ADDR_W; j++) begin : gBit
    if (j == TOP_BIT || j == LOW_TOP) begin : gCopy
      assign grayComb[j] = inAddr[j];
    end else begin : gXor
      assign grayComb[j] = inAddr[j+1] ^ inAddr[j];
    end
  end

  if (REG_OUT) begin : gReg
    logic [ADDR_W-1:0] grayQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          grayQ <= '0;
      else if (ctrl.load) grayQ <= grayComb;
    end
    assign grayOut = grayQ;
  end else begin : gComb
    assign grayOut = grayComb;
  end
endmodule

// File: rtl/gray_seg_ctrl.sv
module gray_seg_ctrl
  import gray_seg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output segCtrl_t ctrl,
  output logic     outValid
);
  always_comb ctrl.load = inValid;

  if (REG_OUT) begin : gReg
    logic validQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validQ <= 1'b0;
      else       validQ <= inValid;
    end
    assign outValid = validQ;
  end else begin : gComb
    assign outValid = inValid;
  end
endmodule

// File: rtl/gray_seg_conv.sv
module gray_seg_conv
  import gray_seg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SPLIT   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              outValid,
  output logic [ADDR_W-1:0] outGray
);
  if (SPLIT < 0 || SPLIT > ADDR_W - 2) begin : gBadSplit
    $error("gray_seg_conv: SPLIT must lie in 0..ADDR_W-2");
  end

  segCtrl_t ctrl;

  gray_seg_ctrl #(.REG_OUT(REG_OUT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  gray_seg_dp #(.ADDR_W(ADDR_W), .SPLIT(SPLIT), .REG_OUT(REG_OUT)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .inAddr  (inAddr),
    .ctrl    (ctrl),
    .grayOut (outGray)
  );
endmodule

// File: rtl/gray_seg_chk.sv
module gray_seg_chk #(
  parameter int ADDR_W  = 8,
  parameter int SPLIT   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [ADDR_W-1:0] inAddr,
  input logic              outValid,
  input logic [ADDR_W-1:0] outGray
);
  if (REG_OUT) begin : gRegChk
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid);                                             // R6
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !outValid);                                           // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> $stable(outGray));                                    // R7
    AST_MSB_COPY: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outGray[ADDR_W-1] == $past(inAddr[ADDR_W-1]));         // R1
    if (SPLIT > 0) begin : gSplitChk
      AST_SPLIT_COPY: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outGray[SPLIT-1] == $past(inAddr[SPLIT-1]));         // R3
    end
    AST_RESET_CLEAR: assert property (@(posedge clk)
      !rstN |=> (outGray == '0 && !outValid));                           // R8
  end else begin : gCombChk
    AST_PASS_VALID: assert property (@(posedge clk) disable iff (!rstN)
      outValid == inValid);                                              // R9
    AST_MSB_COMB: assert property (@(posedge clk) disable iff (!rstN)
      outGray[ADDR_W-1] == inAddr[ADDR_W-1]);                            // R1
  end
endmodule

bind gray_seg_conv gray_seg_chk #(.ADDR_W(ADDR_W), .SPLIT(SPLIT), .REG_OUT(REG_OUT)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inAddr   (inAddr),
  .outValid (outValid),
  .outGray  (outGray)
);

// File: tb/gray_seg_conv_tb_top.sv
`timescale 1ns/100ps
module gray_seg_conv_tb_top;
  localparam int N = 8;
  localparam int K = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [N-1:0] inAddr = '0;
  logic         outValid, combValid;
  logic [N-1:0] outGray, combGray;

  int total = 0;
  int bad = 0;
  logic         drvValid = 1'b0;
  logic [N-1:0] lastGray = '0;
  logic [N-1:0] expQ[$];

  always #2.5 clk = ~clk;

  gray_seg_conv #(.ADDR_W(N), .SPLIT(K), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr),
    .outValid(outValid), .outGray(outGray));

  gray_seg_conv #(.ADDR_W(N), .SPLIT(0), .REG_OUT(1'b0)) dut_comb_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr),
    .outValid(combValid), .outGray(combGray));

  // Reference built from the field rules: whole-word Gray, then restore
  // the lower field's top bit, which must be a plain copy.
  function automatic logic [N-1:0] refGray(input logic [N-1:0] b, input int k);
    logic [N-1:0] g;
    g = b ^ (b >> 1);
    if (k > 0) g[k-1] = b[k-1];
    return g;
  endfunction

  task automatic check(input bit ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [N-1:0] a, input logic v);
    @(negedge clk);
    inAddr = a;
    inValid = v;
    drvValid = v;
    if (v) expQ.push_back(refGray(a, K));
    #1;
    check(combGray == (a ^ (a >> 1)), "R5", combGray, a ^ (a >> 1));
    check(combValid == v, "R9", {7'b0, combValid}, {7'b0, v});
  endtask

  // Scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      check(outValid == drvValid, "R6 valid", {7'b0, outValid}, {7'b0, drvValid});
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected result", outGray, '0);
        end else begin
          logic [N-1:0] e;
          e = expQ.pop_front();
          check(outGray[7] == e[7], "R1", outGray, e);
          check(outGray[6:3] == e[6:3], "R2", outGray, e);
          check(outGray[2] == e[2], "R3", outGray, e);
          check(outGray[1:0] == e[1:0], "R4", outGray, e);
          lastGray = e;
        end
      end else begin
        check(outGray == lastGray, "R7 hold", outGray, lastGray);
      end
    end
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outGray == '0 && outValid == 1'b0, "R8 reset", outGray, '0);
    rstN = 1'b1;
    // Directed corner patterns, back to back.
    drive(8'h00, 1); drive(8'hFF, 1); drive(8'hA5, 1); drive(8'h5A, 1);
    drive(8'h80, 1); drive(8'h04, 1); drive(8'h07, 1); drive(8'h7F, 1);
    // Idle gap with a changing address: output must hold.
    drive(8'h33, 0); drive(8'hCC, 0); drive(8'h99, 0);
    // Exhaustive sweep with occasional gaps.
    for (int a = 0; a < 256; a++) begin
      drive(a[N-1:0], 1);
      if (a % 17 == 0) drive(~a[N-1:0], 0);
    end
    drive(8'h00, 0); drive(8'h00, 0);
    // Mid-run reset with a loaded non-zero result.
    drive(8'hF0, 1); drive(8'h00, 0); drive(8'h00, 0);
    @(negedge clk);
    rstN = 1'b0;
    lastGray = '0;
    #1;
    check(outGray == '0, "R8 async clear", outGray, '0);
    check(outValid == 1'b0, "R8 valid clear", {7'b0, outValid}, 8'h00);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    drive(8'h3C, 1); drive(8'hC3, 1); drive(8'h00, 0); drive(8'h00, 0);
    check(expQ.size() == 0, "R6 drained", N'(expQ.size()), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule